// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 64-bit packed integer adder whose internal carry chain can be cut at byte boundaries. A two-bit width select picks one of four splits: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. A subtract control turns every lane into a two's-complement subtractor. The same single adder does all four operations, so no separate fixed-width adders are needed. The lane count comes from the operation itself and not from any stored length.

Each request is presented with a valid strobe and is registered once. The packed result, a per-lane carry vector and a valid flag appear one clock later. When no request is presented, the outputs keep their last values.

Top module: `simd_lane_adder`

## Requirements
- R1: `outValid` is high in the cycle after each cycle in which `inValid` is high, and low in the cycle after each cycle in which `inValid` is low.
- R2: While reset is held, and in the first cycle after it is released, `outValid`, `sumOut` and `laneCarry` are all zero.
- R3: With `laneMode` = 2'b00, each byte of `sumOut` is the 8-bit sum of the matching bytes of `opA` and `opB`. No carry crosses into the next byte.
- R4: With `laneMode` = 2'b01, each 16-bit half-word of `sumOut` is the 16-bit sum of the matching half-words, computed independently of the other half-words.
- R5: With `laneMode` = 2'b10, each 32-bit word of `sumOut` is the 32-bit sum of the matching words, computed independently of the other word.
- R6: With `laneMode` = 2'b11, `sumOut` is the full 64-bit sum `opA + opB` modulo 2^64.
- R7: With `subtract` high, every active lane gives `opA - opB` modulo 2^(lane width). This is formed by adding the inverted `opB` with a carry-in of 1 at the lowest bit of each lane.
- R8: The carry out of each lane's top bit appears on `laneCarry` at the bit index of that lane's most significant byte. The indices are 0..7 in 8-bit mode, 1,3,5,7 in 16-bit mode, 3,7 in 32-bit mode and 7 in 64-bit mode. When subtracting, this bit is 1 exactly when the lane has no borrow (A ≥ B as unsigned values).
- R9: Bits of `laneCarry` that are not the top byte of an active lane are zero.
- R10: When `inValid` is low, `sumOut` and `laneCarry` keep their previous values, whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands are captured when high |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand (subtrahend when subtracting) |
| laneMode | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| subtract | input | 1 | 1 = subtract, 0 = add |
| outValid | output | 1 | Result valid, one cycle after the request |
| sumOut | output | 64 | Packed lane results |
| laneCarry | output | 8 | Per-lane carry out, placed at each lane's top byte |

## Verification
The checker tests on every cycle that the valid timing is right, that the outputs hold between requests, and that no carry bit appears outside the top byte of an active lane. It also checks the full-width add and subtract against the registered operands. Carry isolation inside the narrower splits, borrow reporting, and the exact carry values under carry-propagating patterns such as all-ones plus one are shown by the bench scenarios. Those scenarios compare each lane against a per-lane reference model.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;
  localparam int SEG_W   = 8;
  localparam int NUM_SEG = 8;
  localparam int DATA_W  = SEG_W * NUM_SEG;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } laneMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SEG-1:0] laneStart; // segment begins a lane: cut carry here
    logic [NUM_SEG-1:0] laneTop;   // segment ends a lane: report carry here
    logic               invertB;   // subtract: invert B, inject carry 1
    logic               capture;   // load output registers
  } addCtrl_t;
endpackage

// File: rtl/simd_add_ctrl.sv
`timescale 1ns/1ps
module simd_add_ctrl
  import simd_add_pkg::*;
#(
  parameter int NSEG = NUM_SEG
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] laneMode,
  input  logic       subtract,
  output addCtrl_t   ctrl,
  output logic       outValid
);
  int segMask;

  always_comb begin
    segMask = (1 << laneMode) - 1;
    ctrl = '0;
    for (int k = 0; k < NSEG; k++) begin
      ctrl.laneStart[k] = ((k & segMask) == 0);
      ctrl.laneTop[k]   = ((k & segMask) == segMask);
    end
    ctrl.invertB = subtract;
    ctrl.capture = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/simd_add_dp.sv
`timescale 1ns/1ps
module simd_add_dp
  import simd_add_pkg::*;
#(
  parameter int SW   = SEG_W,
  parameter int NSEG = NUM_SEG,
  localparam int DW  = SW * NSEG
) (
  input  logic            clk,
  input  logic            rstN,
  input  addCtrl_t        ctrl,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  output logic [DW-1:0]   sumOut,
  output logic [NSEG-1:0] laneCarry
);
  logic [NSEG-1:0] segCin;
  logic [NSEG-1:0] segCout;
  logic [DW-1:0]   segSum;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [SW-1:0] bOp;
    logic [SW:0]   partial;
    if (k == 0) begin : g_first
      assign segCin[k] = ctrl.invertB;
    end else begin : g_rest
      assign segCin[k] = ctrl.laneStart[k] ? ctrl.invertB : segCout[k-1];
    end
    assign bOp     = opB[k*SW +: SW] ^ {SW{ctrl.invertB}};
    assign partial = {1'b0, opA[k*SW +: SW]} + {1'b0, bOp} + {{SW{1'b0}}, segCin[k]};
    assign segSum[k*SW +: SW] = partial[SW-1:0];
    assign segCout[k] = partial[SW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut    <= '0;
      laneCarry <= '0;
    end else if (ctrl.capture) begin
      sumOut    <= segSum;
      laneCarry <= segCout & ctrl.laneTop;
    end
  end
endmodule

// File: rtl/simd_lane_adder.sv
`timescale 1ns/1ps
module simd_lane_adder
  import simd_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        laneMode,
  input  logic              subtract,
  output logic              outValid,
  output logic [DATA_W-1:0] sumOut,
  output logic [NUM_SEG-1:0] laneCarry
);
  addCtrl_t ctrl;

  simd_add_ctrl #(.NSEG(NUM_SEG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneMode(laneMode),
    .subtract(subtract), .ctrl(ctrl), .outValid(outValid)
  );

  simd_add_dp #(.SW(SEG_W), .NSEG(NUM_SEG)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .sumOut(sumOut), .laneCarry(laneCarry)
  );
endmodule

// File: rtl/simd_lane_adder_chk.sv
`timescale 1ns/1ps
module simd_lane_adder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [1:0]  laneMode,
  input logic        subtract,
  input logic        outValid,
  input logic [63:0] sumOut,
  input logic [7:0]  laneCarry
);
  function automatic logic [7:0] topBytes(input logic [1:0] m);
    case (m)
      2'b00:   topBytes = 8'hFF;
      2'b01:   topBytes = 8'hAA;
      2'b10:   topBytes = 8'h88;
      default: topBytes = 8'h80;
    endcase
  endfunction

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sumOut) && $stable(laneCarry))); // R10
  AST_UNUSED_CARRY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((laneCarry & ~topBytes($past(laneMode))) == 8'h00)); // R9
  AST_FULL_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneMode == 2'b11 && !subtract) |=> (sumOut == $past(opA) + $past(opB))); // R6
  AST_FULL_SUB: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneMode == 2'b11 && subtract) |=> (sumOut == $past(opA) - $past(opB))); // R7
endmodule

bind simd_lane_adder simd_lane_adder_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .laneMode(laneMode), .subtract(subtract), .outValid(outValid),
  .sumOut(sumOut), .laneCarry(laneCarry)
);

// File: tb/simd_lane_adder_bench.sv
`timescale 1ns/1ps
module simd_lane_adder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  laneMode = 2'b00;
  logic        subtract = 1'b0;
  logic        outValid;
  logic [63:0] sumOut;
  logic [7:0]  laneCarry;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  simd_lane_adder u_simd_lane_adder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .laneMode(laneMode), .subtract(subtract), .outValid(outValid),
    .sumOut(sumOut), .laneCarry(laneCarry)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent per-lane reference
  task automatic refModel(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                          input logic sub, output logic [63:0] s, output logic [7:0] c);
    int w;
    int n;
    logic [64:0] mask;
    logic [64:0] av, bv, r;
    w = 8 << m;
    n = 64 / w;
    mask = (65'd1 << w) - 65'd1;
    s = '0;
    c = '0;
    for (int l = 0; l < n; l++) begin
      av = ({1'b0, a} >> (l * w)) & mask;
      bv = ({1'b0, b} >> (l * w)) & mask;
      r = sub ? av + ((~bv) & mask) + 65'd1 : av + bv;
      s = s | (r[63:0] & mask[63:0]) << (l * w);
      c[l * (w / 8) + (w / 8) - 1] = r[w];
    end
  endtask

  task automatic runOp(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic sub);
    logic [63:0] es;
    logic [7:0]  ec;
    refModel(a, b, m, sub, es, ec);
    @(negedge clk);
    opA = a; opB = b; laneMode = m; subtract = sub; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check64({req, " R1 valid"}, {63'd0, outValid}, 64'd1);
    check64({req, " sum"}, sumOut, es);
    check64({req, " R8 R9 carry"}, {56'd0, laneCarry}, {56'd0, ec});
  endtask

  task automatic testReset();
    check64("R2 valid", {63'd0, outValid}, 64'd0);
    check64("R2 sum", sumOut, 64'd0);
    check64("R2 carry", {56'd0, laneCarry}, 64'd0);
  endtask

  task automatic testBytes();
    runOp("R3 ones+one", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0);
    runOp("R3 mixed", 64'h8012_7F80_00FF_3C44, 64'h8034_0180_0101_C4BB, 2'b00, 1'b0);
  endtask

  task automatic testHalves();
    runOp("R4 ones+one", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 1'b0);
    runOp("R4 mixed", 64'h1234_FF00_8000_00FF, 64'h0F0F_0100_8000_0001, 2'b01, 1'b0);
  endtask

  task automatic testWords();
    runOp("R5 ones+one", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0);
    runOp("R5 mixed", 64'h7FFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0);
  endtask

  task automatic testFull();
    runOp("R6 ones+one", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0);
    runOp("R6 mixed", 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 2'b11, 1'b0);
  endtask

  task automatic testSubtract();
    runOp("R7 bytes", 64'h0010_FF05_8000_0300, 64'h0001_FF06_0100_0301, 2'b00, 1'b1);
    runOp("R7 halves", 64'h0000_1234_8000_FFFF, 64'h0001_1234_0001_0000, 2'b01, 1'b1);
    runOp("R7 words", 64'h0000_0000_5555_5555, 64'h0000_0001_1111_1111, 2'b10, 1'b1);
    runOp("R7 full", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b11, 1'b1);
  endtask

  task automatic testHold();
    logic [63:0] keepS;
    logic [7:0]  keepC;
    runOp("R10 setup", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0);
    keepS = sumOut;
    keepC = laneCarry;
    opA = 64'h1111_2222_3333_4444; opB = 64'h5555_6666_7777_8888;
    laneMode = 2'b11; subtract = 1'b1;
    repeat (3) @(negedge clk);
    check64("R10 R1 idle valid", {63'd0, outValid}, 64'd0);
    check64("R10 sum held", sumOut, keepS);
    check64("R10 carry held", {56'd0, laneCarry}, {56'd0, keepC});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBytes();
    testHalves();
    testWords();
    testFull();
    testSubtract();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule